// File: doc/BRIEF.md
# Interrupt Source Configuration Unit

This block keeps the per-source setup of an interrupt controller and decides, source by source, when an interrupt must be handed on to the CPUs. Each source owns two registers. The control word holds a mask, a read-only activity flag, a delivery-mode bit, polarity and sense bits, a 4-bit priority and a vector. The target word holds one enable bit per CPU plus two spare bits that are kept but have no effect. Raw interrupt lines are sampled on the clock. Each source keeps a pending flag, fed by its line as set by the sense bit, and an activity flag that marks an interrupt already handed on.

When a source is pending, unmasked, has nonzero priority, is not active and has at least one CPU bit set, the block raises a one-cycle forward request for it. The request carries the priority, vector and CPU mask. The same clock edge marks the source active. Downstream arbitration picks among the requests. Acknowledge logic returns an activity-clear pulse per source.

Software reaches the registers through a plain write/read port addressed by source index and a register select. Reads return the register contents one clock after the request.

Top module: `irq_src_cfg`

## Requirements
- R1: After reset every control word reads 0xA0000000 (mask bit 31 and mode bit 29 set), every target word reads 0, and no forward request is raised.
- R2: A control-word write keeps the current activity bit (bit 30) and stores only the written bits selected by 0xA0CF00FF. Those are mask 31, mode 29, polarity 23, sense 22 (1 = level, 0 = edge), priority 19:16 and vector 7:0. Every other bit reads 0.
- R3: A target-word write stores written bits 31:30 and bits N_CPU-1:0 (one per CPU). Every other bit reads 0.
- R4: A read (cfg_sel 0 = control word, 1 = target word) returns the register value on cfg_rdata after the next rising edge. An index at or above N_SRC reads 0, and a write to such an index changes no register.
- R5: For an edge-sensitive source, a 0-to-1 transition of the line sets pending. With the source enabled, fwd_req rises after the second rising edge following the line change.
- R6: For a level-sensitive source, pending follows the sampled line. A low sampled line clears the activity flag, and a line that goes low before forwarding leaves nothing pending.
- R7: A source is forwarded only when it is pending, unmasked, has nonzero priority, is not active and has a nonzero CPU field (bits 31:30 of the target word do not count). A pending source that was held back by its mask is forwarded as soon as it is unmasked.
- R8: Forwarding sets the activity flag, so each fwd_req pulse lasts one cycle and is not repeated while the flag stays set.
- R9: An activity-clear pulse on an edge-sensitive source clears both pending and activity, so a held-high line is not forwarded again until it makes a new 0-to-1 transition. The pulse has no effect on a level-sensitive source.
- R10: During a request, fwd_prio, fwd_vec and fwd_dest carry the source's priority, vector and CPU field in the slice for that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_SRC | Raw interrupt lines, one per source |
| ack_clr | input | N_SRC | Activity-clear pulses from the acknowledge logic |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_sel | input | 1 | 0 selects the control word, 1 the target word |
| cfg_idx | input | IDX_W | Source index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid one clock after cfg_rd |
| fwd_req | output | N_SRC | One-cycle forward request per source |
| fwd_prio | output | N_SRC*4 | Priority of each source |
| fwd_vec | output | N_SRC*VEC_W | Vector of each source |
| fwd_dest | output | N_SRC*N_CPU | CPU mask of each source |

## Verification
The hardest case to reach is a pending flag that exists while nothing can be seen at the outputs. Examples are an edge event captured while the source is masked, or a level line that falls before the source is enabled. Only a later unmask shows whether pending was kept or lost. The stimulus raises the line on a masked source, waits, changes the line or leaves it alone, and then unmasks through the register port. It checks for a request, or for its absence, on the very next cycle. Activity is watched through bit 30 of the control word read back after acknowledge pulses and line changes.

// File: rtl/irq_src_cfg_pkg.sv
package irq_src_cfg_pkg;
   localparam int          BIT_MASK  = 31;
   localparam int          BIT_ACT   = 30;
   localparam int          BIT_MODE  = 29;
   localparam int          BIT_POL   = 23;
   localparam int          BIT_SENSE = 22;
   localparam int          PRIO_LSB  = 16;
   localparam int          PRIO_W    = 4;
   localparam logic [31:0] CTRL_RESET = 32'hA000_0000;

   typedef enum logic {
      SEL_CTRL   = 1'b0,
      SEL_TARGET = 1'b1
   } cfg_sel_e;
endpackage

// File: rtl/irq_line_sampler.sv
module irq_line_sampler #(
   parameter int N_SRC       = 16,
   parameter int SYNC_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] line_in,
   output logic [N_SRC-1:0] line_lvl,
   output logic [N_SRC-1:0] line_rise
);
   logic [N_SRC-1:0] stage_q [SYNC_STAGES];
   logic [N_SRC-1:0] prev_q;

   generate
      if (SYNC_STAGES < 1) begin : g_bad
         $error("SYNC_STAGES must be at least 1");
      end
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       stage_q[s] <= '0;
            else if (s == 0)  stage_q[s] <= line_in;
            else              stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= stage_q[SYNC_STAGES-1];
   end

   assign line_lvl  = stage_q[SYNC_STAGES-1];
   assign line_rise = stage_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/irq_src_slot.sv
module irq_src_slot
   import irq_src_cfg_pkg::*;
#(
   parameter int N_CPU = 2,
   parameter int VEC_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_target,
   input  logic [31:0]       wdata,
   input  logic              lvl,
   input  logic              rise,
   input  logic              ack,
   output logic              fwd,
   output logic [PRIO_W-1:0] prio,
   output logic [VEC_W-1:0]  vec,
   output logic [N_CPU-1:0]  dest,
   output logic [31:0]       ctrl_rd,
   output logic [31:0]       target_rd
);
   logic              mask_q, mode_q, pol_q, sense_q;
   logic [PRIO_W-1:0] prio_q;
   logic [VEC_W-1:0]  vec_q;
   logic              act_q, pend_q;
   logic [1:0]        spare_q;
   logic [N_CPU-1:0]  cpu_q;

   // control and target words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= CTRL_RESET[BIT_MASK];
         mode_q  <= CTRL_RESET[BIT_MODE];
         pol_q   <= 1'b0;
         sense_q <= 1'b0;
         prio_q  <= '0;
         vec_q   <= '0;
         spare_q <= '0;
         cpu_q   <= '0;
      end else begin
         if (wr_ctrl) begin
            mask_q  <= wdata[BIT_MASK];
            mode_q  <= wdata[BIT_MODE];
            pol_q   <= wdata[BIT_POL];
            sense_q <= wdata[BIT_SENSE];
            prio_q  <= wdata[PRIO_LSB +: PRIO_W];
            vec_q   <= wdata[VEC_W-1:0];
         end
         if (wr_target) begin
            spare_q <= wdata[31:30];
            cpu_q   <= wdata[N_CPU-1:0];
         end
      end
   end

   assign fwd = pend_q & ~mask_q & (prio_q != '0) & ~act_q & (|cpu_q);

   // pending and activity tracking
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         act_q  <= 1'b0;
      end else begin
         if (sense_q)   pend_q <= lvl;
         else if (rise) pend_q <= 1'b1;
         else if (ack)  pend_q <= 1'b0;

         if (fwd)                  act_q <= 1'b1;
         else if (sense_q && !lvl) act_q <= 1'b0;
         else if (!sense_q && ack) act_q <= 1'b0;
      end
   end

   always_comb begin
      ctrl_rd              = '0;
      ctrl_rd[BIT_MASK]    = mask_q;
      ctrl_rd[BIT_ACT]     = act_q;
      ctrl_rd[BIT_MODE]    = mode_q;
      ctrl_rd[BIT_POL]     = pol_q;
      ctrl_rd[BIT_SENSE]   = sense_q;
      ctrl_rd[PRIO_LSB +: PRIO_W] = prio_q;
      ctrl_rd[VEC_W-1:0]   = vec_q;
      target_rd            = '0;
      target_rd[31:30]     = spare_q;
      target_rd[N_CPU-1:0] = cpu_q;
   end

   assign prio = prio_q;
   assign vec  = vec_q;
   assign dest = cpu_q;

   AST_FWD_SETS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      fwd |=> act_q);                                            // R8
   AST_FWD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      fwd |=> !fwd);                                             // R8
   AST_EDGE_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (!sense_q && ack && !rise && !fwd) |=> (!act_q && !pend_q)); // R9
   AST_LEVEL_LOW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_q && !lvl && !fwd) |=> !act_q);                     // R6
endmodule

// File: rtl/irq_src_cfg.sv
module irq_src_cfg
   import irq_src_cfg_pkg::*;
#(
   parameter int N_SRC       = 16,
   parameter int N_CPU       = 2,
   parameter int VEC_W       = 8,
   parameter int IDX_W       = 5,
   parameter int SYNC_STAGES = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_SRC-1:0]         irq_in,
   input  logic [N_SRC-1:0]         ack_clr,
   input  logic                     cfg_wr,
   input  logic                     cfg_rd,
   input  logic                     cfg_sel,
   input  logic [IDX_W-1:0]         cfg_idx,
   input  logic [31:0]              cfg_wdata,
   output logic [31:0]              cfg_rdata,
   output logic [N_SRC-1:0]         fwd_req,
   output logic [N_SRC*PRIO_W-1:0]  fwd_prio,
   output logic [N_SRC*VEC_W-1:0]   fwd_vec,
   output logic [N_SRC*N_CPU-1:0]   fwd_dest
);
   localparam int IDX_SPAN = 1 << IDX_W;

   generate
      if (N_SRC < 1 || N_SRC > IDX_SPAN) begin : g_bad_src
         $error("N_SRC must be between 1 and 2**IDX_W");
      end
      if (N_CPU < 1 || N_CPU > 30) begin : g_bad_cpu
         $error("N_CPU must be between 1 and 30");
      end
      if (VEC_W < 1 || VEC_W > 16) begin : g_bad_vec
         $error("VEC_W must be between 1 and 16");
      end
   endgenerate

   logic [N_SRC-1:0] lvl, rise;
   logic [31:0]      ctrl_rd   [N_SRC];
   logic [31:0]      target_rd [N_SRC];
   logic [31:0]      rd_mux;

   irq_line_sampler #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (irq_in),
      .line_lvl  (lvl),
      .line_rise (rise)
   );

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_src
         logic hit;
         assign hit = cfg_wr && (cfg_idx == IDX_W'(i));
         irq_src_slot #(.N_CPU(N_CPU), .VEC_W(VEC_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctrl   (hit && (cfg_sel == SEL_CTRL)),
            .wr_target (hit && (cfg_sel == SEL_TARGET)),
            .wdata     (cfg_wdata),
            .lvl       (lvl[i]),
            .rise      (rise[i]),
            .ack       (ack_clr[i]),
            .fwd       (fwd_req[i]),
            .prio      (fwd_prio[i*PRIO_W +: PRIO_W]),
            .vec       (fwd_vec[i*VEC_W +: VEC_W]),
            .dest      (fwd_dest[i*N_CPU +: N_CPU]),
            .ctrl_rd   (ctrl_rd[i]),
            .target_rd (target_rd[i])
         );
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (cfg_idx == IDX_W'(i))
            rd_mux = (cfg_sel == SEL_TARGET) ? target_rd[i] : ctrl_rd[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_rdata <= '0;
      else if (cfg_rd) cfg_rdata <= rd_mux;
   end

   AST_RD_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && ({1'b0, cfg_idx} >= (IDX_W+1)'(N_SRC))) |=> (cfg_rdata == '0)); // R4
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_rd && !$past(!rst_n)) |=> $stable(cfg_rdata));                       // R4
endmodule

// File: tb/irq_src_cfg_tb.sv
module irq_src_cfg_tb;
   localparam int N_SRC = 16;
   localparam int N_CPU = 2;
   localparam int VEC_W = 8;
   localparam int IDX_W = 5;

   typedef struct packed {
      logic             sel;
      logic [IDX_W-1:0] idx;
      logic [31:0]      wd;
      logic [31:0]      exp;
   } vec_t;

   localparam vec_t TBL [6] = '{
      '{1'b0, 5'd9,  32'hFFFF_FFFF, 32'hA0CF_00FF},
      '{1'b1, 5'd9,  32'hFFFF_FFFF, 32'hC000_0003},
      '{1'b0, 5'd10, 32'h1234_5678, 32'h0004_0078},
      '{1'b1, 5'd10, 32'h5555_AAAA, 32'h4000_0002},
      '{1'b0, 5'd11, 32'h800F_00A5, 32'h800F_00A5},
      '{1'b1, 5'd11, 32'h0000_0000, 32'h0000_0000}
   };

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [N_SRC-1:0]     irq_in = '0;
   logic [N_SRC-1:0]     ack_clr = '0;
   logic                 cfg_wr = 1'b0, cfg_rd = 1'b0, cfg_sel = 1'b0;
   logic [IDX_W-1:0]     cfg_idx = '0;
   logic [31:0]          cfg_wdata = '0;
   logic [31:0]          cfg_rdata;
   logic [N_SRC-1:0]     fwd_req;
   logic [N_SRC*4-1:0]   fwd_prio;
   logic [N_SRC*VEC_W-1:0] fwd_vec;
   logic [N_SRC*N_CPU-1:0] fwd_dest;

   int n_chk = 0;
   int n_err = 0;
   logic [31:0] rv;

   always #2 clk = ~clk;

   irq_src_cfg #(.N_SRC(N_SRC), .N_CPU(N_CPU), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_clr(ack_clr),
      .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fwd_req(fwd_req),
      .fwd_prio(fwd_prio), .fwd_vec(fwd_vec), .fwd_dest(fwd_dest)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic sel, input int idx, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_idx = IDX_W'(idx); cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic sel, input int idx, output logic [31:0] d);
      @(negedge clk);
      cfg_rd = 1'b1; cfg_sel = sel; cfg_idx = IDX_W'(idx);
      @(negedge clk);
      cfg_rd = 1'b0;
      d = cfg_rdata;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=expired expected=done");
      finish_run();
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 no request", 32'(fwd_req), 32'h0);
      rd_reg(1'b0, 0, rv); chk("R1 control reset", rv, 32'hA000_0000);
      rd_reg(1'b1, 0, rv); chk("R1 target reset", rv, 32'h0);

      // R2 R3 R4 table walk: write then read back
      foreach (TBL[k]) begin
         wr_reg(TBL[k].sel, int'(TBL[k].idx), TBL[k].wd);
         rd_reg(TBL[k].sel, int'(TBL[k].idx), rv);
         chk(TBL[k].sel ? "R3 target write" : "R2 control write", rv, TBL[k].exp);
      end

      // R5 R10 edge source 3: prio 5, vec 0x33, cpu0
      wr_reg(1'b1, 3, 32'h0000_0001);
      wr_reg(1'b0, 3, 32'h0005_0033);
      irq_in[3] = 1'b1;
      cyc(1); chk("R5 not yet after one edge", 32'(fwd_req[3]), 32'h0);
      cyc(1); chk("R5 request after two edges", 32'(fwd_req[3]), 32'h1);
      chk("R10 priority", 32'(fwd_prio[3*4 +: 4]), 32'h5);
      chk("R10 vector", 32'(fwd_vec[3*VEC_W +: VEC_W]), 32'h33);
      chk("R10 cpu mask", 32'(fwd_dest[3*N_CPU +: N_CPU]), 32'h1);
      cyc(1); chk("R8 one-cycle pulse", 32'(fwd_req[3]), 32'h0);
      rd_reg(1'b0, 3, rv); chk("R8 activity set", rv, 32'h4005_0033);
      // R2 write keeps activity
      wr_reg(1'b0, 3, 32'h0005_0034);
      rd_reg(1'b0, 3, rv); chk("R2 activity preserved", rv, 32'h4005_0034);
      // R9 acknowledge clears, no repeat while held high
      @(negedge clk); ack_clr[3] = 1'b1;
      @(negedge clk); ack_clr[3] = 1'b0;
      rd_reg(1'b0, 3, rv); chk("R9 ack clears activity", rv, 32'h0005_0034);
      cyc(3); chk("R9 no request without new rise", 32'(fwd_req[3]), 32'h0);
      irq_in[3] = 1'b0; cyc(3);
      irq_in[3] = 1'b1; cyc(2);
      chk("R9 new rise forwarded", 32'(fwd_req[3]), 32'h1);

      // R7 masked source keeps pending, forwarded on unmask
      wr_reg(1'b1, 4, 32'h0000_0001);
      wr_reg(1'b0, 4, 32'h8006_0044);
      irq_in[4] = 1'b1; cyc(4);
      chk("R7 masked held back", 32'(fwd_req[4]), 32'h0);
      wr_reg(1'b0, 4, 32'h0006_0044);
      chk("R7 unmask forwards", 32'(fwd_req[4]), 32'h1);

      // R7 zero priority and empty cpu field
      wr_reg(1'b1, 5, 32'h0000_0001);
      wr_reg(1'b0, 5, 32'h0000_0055);
      wr_reg(1'b1, 6, 32'hC000_0000);
      wr_reg(1'b0, 6, 32'h0002_0066);
      irq_in[5] = 1'b1; irq_in[6] = 1'b1; cyc(4);
      chk("R7 zero priority blocked", 32'(fwd_req[5]), 32'h0);
      chk("R7 empty cpu field blocked", 32'(fwd_req[6]), 32'h0);

      // R4 out-of-range index
      wr_reg(1'b0, 20, 32'h000F_00FF);
      rd_reg(1'b0, 20, rv); chk("R4 out-of-range reads zero", rv, 32'h0);
      rd_reg(1'b0, 4, rv);  chk("R4 no aliased write", rv, 32'h4006_0044);

      // R6 level source 7: sense bit 22, prio 3, vec 0x77, cpu1
      wr_reg(1'b1, 7, 32'h0000_0002);
      wr_reg(1'b0, 7, 32'h0043_0077);
      irq_in[7] = 1'b1;
      cyc(1); chk("R6 level not yet", 32'(fwd_req[7]), 32'h0);
      cyc(1); chk("R6 level forwarded", 32'(fwd_req[7]), 32'h1);
      chk("R10 level cpu mask", 32'(fwd_dest[7*N_CPU +: N_CPU]), 32'h2);
      cyc(4); chk("R8 no repeat while active", 32'(fwd_req[7]), 32'h0);
      @(negedge clk); ack_clr[7] = 1'b1;
      @(negedge clk); ack_clr[7] = 1'b0;
      rd_reg(1'b0, 7, rv); chk("R9 ack ignored on level", rv, 32'h4043_0077);
      irq_in[7] = 1'b0; cyc(3);
      rd_reg(1'b0, 7, rv); chk("R6 low clears activity", rv, 32'h0043_0077);
      irq_in[7] = 1'b1; cyc(2);
      chk("R6 level forwarded again", 32'(fwd_req[7]), 32'h1);

      // R6 level line dropped while masked leaves nothing pending
      wr_reg(1'b1, 8, 32'h0000_0001);
      wr_reg(1'b0, 8, 32'h8043_0088);
      irq_in[8] = 1'b1; cyc(3);
      irq_in[8] = 1'b0; cyc(3);
      wr_reg(1'b0, 8, 32'h0043_0088);
      chk("R6 dropped level not forwarded", 32'(fwd_req[8]), 32'h0);

      finish_run();
   end
endmodule